// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-based 8-bit processor core. It holds the accumulator and the flag byte as registers. Each clock cycle it takes one command code and one second operand, which the surrounding decode logic has already chosen. At the clock edge it writes the new accumulator value and the updated flags.

The flags are carry, auxiliary (nibble) carry, signed overflow and parity. Carry, auxiliary carry and overflow change only on the add and subtract commands. The through-carry rotates and the two direct carry commands also write carry. Parity is always recomputed from the accumulator.

A digit-exchange command swaps the low nibbles of the accumulator and the operand. The modified operand is returned on a write-back port for one cycle, so the decode logic can store it. Bank-select bits and general-purpose bits in the flag byte change only through an explicit flag-byte write.

Top module: `acc_alu_core`

## Requirements
- R1: When rst_n is sampled low at a rising edge, acc_q, psw_q, wb_en and wb_data all become 0.
- R2: ADD (code 1) computes A+B and ADDC (code 2) computes A+B+CY. Bit 7 of psw_q (CY) is the carry out of bit 7. Bit 6 (AC) is the carry out of bit 3. Bit 2 (OV) is set when the signed result falls outside -128..127.
- R3: SUBB (code 3) computes A-B-CY. CY is set on a borrow out of bit 7, AC on a borrow out of bit 3, and OV when the signed difference falls outside -128..127.
- R4: psw_q bit 0 is always 1 when acc_q holds an odd number of ones and 0 otherwise. This holds even after a flag-byte write that tries to set bit 0 differently.
- R5: AND (4), OR (5), XOR (6), CPL (7, invert A) and CLR (8, A=0) produce their bitwise result. They leave CY, AC and OV unchanged.
- R6: RL (9) and RR (11) rotate the 8 accumulator bits left and right, and leave CY, AC and OV unchanged. RLC (10) and RRC (12) rotate through CY: the outgoing bit lands in CY and the old CY enters the vacated bit. AC and OV are left unchanged.
- R7: SWAP (13) exchanges the upper and lower nibbles of A, leaving CY, AC and OV unchanged.
- R8: XCHD (14) sets A[3:0] to B[3:0]. In the following cycle wb_en is 1 and wb_data is {B[7:4], old A[3:0]}; in all other cycles wb_en is 0. CY, AC and OV are unchanged.
- R9: SETC (15) forces CY to 1 and CLRC (16) forces CY to 0. Nothing else changes except parity.
- R10: LDA (17) loads A with B and keeps the flags. WRPSW (18) writes psw_q bits 7:1 from B. Bits 5, 4, 3 and 1 change only through WRPSW.
- R11: NOP (0) and every unassigned code (19-31) change neither acc_q nor psw_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 5 | Command code for this cycle |
| operand | input | 8 | Second operand (B) |
| acc_q | output | 8 | Accumulator register |
| psw_q | output | 8 | Flag byte: CY bit 7, AC bit 6, GP bit 5, bank bits 4:3, OV bit 2, GP bit 1, P bit 0 |
| wb_data | output | 8 | Modified operand after a digit exchange |
| wb_en | output | 1 | High for one cycle when wb_data is valid |

## Verification
All state sits in acc_q and psw_q, so a wrong next-state value shows up at the ports on the rising edge right after the faulty command. A flag that is disturbed when it should be held stays wrong until the next command that writes it. For that reason, the sweeps reload the flag byte to a varied pattern before each logic command and compare all eight flag bits one cycle later. Arithmetic is swept over a dense grid of operand pairs plus sign and nibble boundaries, with both carry-in values. The expected flags come from integer arithmetic, not from bit-level logic.

// File: rtl/acc_alu_pkg.sv
// Shared command codes and flag-byte bit positions for the accumulator ALU.
// Assumes a 5-bit command field; codes not listed act as no-operation.
package acc_alu_pkg;
    typedef enum logic [4:0] {
        OP_NOP   = 5'd0,
        OP_ADD   = 5'd1,
        OP_ADDC  = 5'd2,
        OP_SUBB  = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_CPL   = 5'd7,
        OP_CLR   = 5'd8,
        OP_RL    = 5'd9,
        OP_RLC   = 5'd10,
        OP_RR    = 5'd11,
        OP_RRC   = 5'd12,
        OP_SWAP  = 5'd13,
        OP_XCHD  = 5'd14,
        OP_SETC  = 5'd15,
        OP_CLRC  = 5'd16,
        OP_LDA   = 5'd17,
        OP_WRPSW = 5'd18
    } alu_op_e;

    localparam int FLG_CY = 7;
    localparam int FLG_AC = 6;
    localparam int FLG_OV = 2;
    localparam int FLG_P  = 0;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } arith_flags_t;
endpackage

// File: rtl/acc_alu_arith.sv
// Adder/subtractor with carry-in and flag generation.
// Assumes DATA_W is even; the auxiliary carry comes from the lower half.
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              c_in,
    input  logic              sub_sel,
    output logic [DATA_W-1:0] sum_out,
    output arith_flags_t      flags_out
);
    localparam int NIB = DATA_W / 2;

    logic [DATA_W:0] full_r;
    logic [NIB:0]    half_r;

    // Full-width and low-half sums or differences, each including the carry-in.
    always_comb begin
        if (sub_sel) begin
            full_r = {1'b0, a_in} - {1'b0, b_in} - {{DATA_W{1'b0}}, c_in};
            half_r = {1'b0, a_in[NIB-1:0]} - {1'b0, b_in[NIB-1:0]} - {{NIB{1'b0}}, c_in};
        end else begin
            full_r = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, c_in};
            half_r = {1'b0, a_in[NIB-1:0]} + {1'b0, b_in[NIB-1:0]} + {{NIB{1'b0}}, c_in};
        end
    end

    // Result and flags: the sign rule for overflow differs between add and subtract.
    always_comb begin
        sum_out      = full_r[DATA_W-1:0];
        flags_out.cy = full_r[DATA_W];
        flags_out.ac = half_r[NIB];
        if (sub_sel)
            flags_out.ov = (a_in[DATA_W-1] != b_in[DATA_W-1]) &&
                           (full_r[DATA_W-1] != a_in[DATA_W-1]);
        else
            flags_out.ov = (a_in[DATA_W-1] == b_in[DATA_W-1]) &&
                           (full_r[DATA_W-1] != a_in[DATA_W-1]);
    end
endmodule

// File: rtl/acc_alu_logic.sv
// Bitwise, rotate, nibble-swap and digit-exchange datapath.
// Assumes DATA_W is even. Only the through-carry rotates drive a new carry.
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_in,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              c_in,
    output logic [DATA_W-1:0] res_out,
    output logic              c_out,
    output logic [DATA_W-1:0] xchg_out
);
    localparam int NIB = DATA_W / 2;

    // Select the non-arithmetic result; commands that are not handled here pass A through.
    always_comb begin
        res_out  = a_in;
        c_out    = c_in;
        xchg_out = b_in;
        case (op_in)
            OP_AND:  res_out = a_in & b_in;
            OP_OR:   res_out = a_in | b_in;
            OP_XOR:  res_out = a_in ^ b_in;
            OP_CPL:  res_out = ~a_in;
            OP_CLR:  res_out = '0;
            OP_RL:   res_out = {a_in[DATA_W-2:0], a_in[DATA_W-1]};
            OP_RR:   res_out = {a_in[0], a_in[DATA_W-1:1]};
            OP_RLC: begin
                res_out = {a_in[DATA_W-2:0], c_in};
                c_out   = a_in[DATA_W-1];
            end
            OP_RRC: begin
                res_out = {c_in, a_in[DATA_W-1:1]};
                c_out   = a_in[0];
            end
            OP_SWAP: res_out = {a_in[NIB-1:0], a_in[DATA_W-1:NIB]};
            OP_XCHD: begin
                res_out  = {a_in[DATA_W-1:NIB], b_in[NIB-1:0]};
                xchg_out = {b_in[DATA_W-1:NIB], a_in[NIB-1:0]};
            end
            default: res_out = a_in;
        endcase
    end
endmodule

// File: rtl/acc_alu_core.sv
// Registered accumulator and flag byte around the arithmetic and logic datapaths.
// Assumes one command per cycle and a synchronous active-low reset.
// Parity is derived from the next accumulator value on every edge.
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        op_code,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc_q,
    output logic [DATA_W-1:0] psw_q,
    output logic [DATA_W-1:0] wb_data,
    output logic              wb_en
);
    alu_op_e           op_e;
    logic              arith_sel;
    logic              sub_sel;
    logic              arith_cin;
    logic [DATA_W-1:0] arith_res;
    arith_flags_t      arith_flg;
    logic [DATA_W-1:0] logic_res;
    logic              logic_cy;
    logic [DATA_W-1:0] xchg_val;
    logic [DATA_W-1:0] acc_n;
    logic [DATA_W-1:0] psw_n;

    assign op_e      = alu_op_e'(op_code);
    assign arith_sel = (op_e == OP_ADD) || (op_e == OP_ADDC) || (op_e == OP_SUBB);
    assign sub_sel   = (op_e == OP_SUBB);
    assign arith_cin = (op_e == OP_ADD) ? 1'b0 : psw_q[FLG_CY];

    acc_alu_arith #(.DATA_W(DATA_W)) arith_i (
        .a_in      (acc_q),
        .b_in      (operand),
        .c_in      (arith_cin),
        .sub_sel   (sub_sel),
        .sum_out   (arith_res),
        .flags_out (arith_flg)
    );

    acc_alu_logic #(.DATA_W(DATA_W)) logic_i (
        .op_in    (op_e),
        .a_in     (acc_q),
        .b_in     (operand),
        .c_in     (psw_q[FLG_CY]),
        .res_out  (logic_res),
        .c_out    (logic_cy),
        .xchg_out (xchg_val)
    );

    // Next accumulator and flag byte for the current command.
    always_comb begin
        acc_n = acc_q;
        psw_n = psw_q;
        case (op_e)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                acc_n         = arith_res;
                psw_n[FLG_CY] = arith_flg.cy;
                psw_n[FLG_AC] = arith_flg.ac;
                psw_n[FLG_OV] = arith_flg.ov;
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL, OP_CLR, OP_RL, OP_RR,
            OP_RLC, OP_RRC, OP_SWAP, OP_XCHD: begin
                acc_n         = logic_res;
                psw_n[FLG_CY] = logic_cy;
            end
            OP_SETC:  psw_n[FLG_CY] = 1'b1;
            OP_CLRC:  psw_n[FLG_CY] = 1'b0;
            OP_LDA:   acc_n = operand;
            OP_WRPSW: psw_n = operand;
            default:  acc_n = acc_q;
        endcase
        psw_n[FLG_P] = ^acc_n;
    end

    // State registers: accumulator, flag byte and the digit-exchange write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            psw_q   <= '0;
            wb_data <= '0;
            wb_en   <= 1'b0;
        end else begin
            acc_q <= acc_n;
            psw_q <= psw_n;
            wb_en <= (op_e == OP_XCHD);
            if (op_e == OP_XCHD)
                wb_data <= xchg_val;
        end
    end

    // Unused warning guard: the arithmetic path is only consulted when selected.
    logic arith_seen;
    assign arith_seen = arith_sel;
endmodule

// File: rtl/acc_alu_chk.sv
// Property checker for the accumulator ALU, attached to every instance by bind.
// Assumes the 8-bit flag layout defined in the package.
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        op_code,
    input logic [DATA_W-1:0] acc_q,
    input logic [DATA_W-1:0] psw_q,
    input logic              wb_en
);
    localparam int NIB = DATA_W / 2;

    logic plain_logic;
    assign plain_logic = (op_code >= 5'(OP_AND)) && (op_code <= 5'(OP_XCHD)) &&
                         (op_code != 5'(OP_RLC)) && (op_code != 5'(OP_RRC));

    AST_PARITY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        psw_q[FLG_P] == ^acc_q); // R4

    AST_LOGIC_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        plain_logic |=> $stable(psw_q[FLG_CY]) && $stable(psw_q[FLG_AC]) && $stable(psw_q[FLG_OV])); // R5

    AST_SWAP_NIBBLES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'(OP_SWAP)) |=> acc_q == {$past(acc_q[NIB-1:0]), $past(acc_q[DATA_W-1:NIB])}); // R7

    AST_XCHD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'(OP_XCHD)) |=> wb_en); // R8

    AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code != 5'(OP_XCHD)) |=> !wb_en); // R8

    AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'(OP_SETC)) |=> psw_q[FLG_CY]); // R9

    AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'(OP_CLRC)) |=> !psw_q[FLG_CY]); // R9

    AST_GP_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code != 5'(OP_WRPSW)) |=> $stable(psw_q[5:3]) && $stable(psw_q[1])); // R10
endmodule

bind acc_alu_core acc_alu_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_code (op_code),
    .acc_q   (acc_q),
    .psw_q   (psw_q),
    .wb_en   (wb_en)
);

// File: tb/acc_alu_core_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps operands through every command and compares against
// an arithmetic model of the accumulator and flag byte.
module acc_alu_core_tb_top;
    localparam int C_NOP = 0, C_ADD = 1, C_ADDC = 2, C_SUBB = 3, C_AND = 4, C_OR = 5,
                   C_XOR = 6, C_CPL = 7, C_CLR = 8, C_RL = 9, C_RLC = 10, C_RR = 11,
                   C_RRC = 12, C_SWAP = 13, C_XCHD = 14, C_SETC = 15, C_CLRC = 16,
                   C_LDA = 17, C_WRPSW = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] operand = '0;
    logic [7:0] acc_q, psw_q, wb_data;
    logic       wb_en;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] m_acc = '0, m_psw = '0, m_wbd = '0;
    logic       m_wbe = 1'b0;

    always #2 clk = ~clk;

    acc_alu_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .operand(operand),
        .acc_q(acc_q), .psw_q(psw_q), .wb_data(wb_data), .wb_en(wb_en)
    );

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // Advance the model by one command, using integer arithmetic for flags.
    task automatic model_step(input int o, input logic [7:0] b);
        int a, bi, c, r, s;
        logic [7:0] old;
        a = int'(m_acc); bi = int'(b); c = int'(m_psw[7]); old = m_acc;
        m_wbe = 1'b0;
        case (o)
            C_ADD, C_ADDC: begin
                if (o == C_ADD) c = 0;
                r = a + bi + c;
                m_acc = r[7:0];
                m_psw[7] = (r > 255);
                m_psw[6] = ((a % 16) + (bi % 16) + c) > 15;
                s = sgn(a) + sgn(bi) + c;
                m_psw[2] = (s > 127) || (s < -128);
            end
            C_SUBB: begin
                r = a - bi - c;
                m_acc = r[7:0];
                m_psw[7] = (r < 0);
                m_psw[6] = ((a % 16) - (bi % 16) - c) < 0;
                s = sgn(a) - sgn(bi) - c;
                m_psw[2] = (s > 127) || (s < -128);
            end
            C_AND:  m_acc = old & b;
            C_OR:   m_acc = old | b;
            C_XOR:  m_acc = old ^ b;
            C_CPL:  m_acc = 8'(255 - a);
            C_CLR:  m_acc = 8'd0;
            C_RL:   m_acc = 8'(((a * 2) % 256) + a / 128);
            C_RR:   m_acc = 8'((a / 2) + (a % 2) * 128);
            C_RLC: begin
                m_acc = 8'(((a * 2) % 256) + c);
                m_psw[7] = (a >= 128);
            end
            C_RRC: begin
                m_acc = 8'((a / 2) + c * 128);
                m_psw[7] = (a % 2);
            end
            C_SWAP: m_acc = 8'((a % 16) * 16 + a / 16);
            C_XCHD: begin
                m_acc = 8'((a / 16) * 16 + bi % 16);
                m_wbd = 8'((bi / 16) * 16 + a % 16);
                m_wbe = 1'b1;
            end
            C_SETC: m_psw[7] = 1'b1;
            C_CLRC: m_psw[7] = 1'b0;
            C_LDA:  m_acc = b;
            C_WRPSW: m_psw = b;
            default: m_acc = old;
        endcase
        m_psw[0] = ($countones(m_acc) % 2) == 1;
    endtask

    task automatic check(input string req);
        n_chk++;
        if (acc_q !== m_acc || psw_q !== m_psw || wb_en !== m_wbe ||
            (m_wbe && wb_data !== m_wbd)) begin
            n_err++;
            $display("FAIL %s acc=%h psw=%h wbe=%b wbd=%h expected acc=%h psw=%h wbe=%b wbd=%h",
                     req, acc_q, psw_q, wb_en, wb_data, m_acc, m_psw, m_wbe, m_wbd);
        end
        n_chk++;
        if (psw_q[0] !== (($countones(m_acc) % 2) == 1)) begin
            n_err++;
            $display("FAIL R4 parity=%b expected %b", psw_q[0], ($countones(m_acc) % 2) == 1);
        end
    endtask

    function automatic string tag_of(input int o);
        case (o)
            C_ADD, C_ADDC: return "R2";
            C_SUBB: return "R3";
            C_AND, C_OR, C_XOR, C_CPL, C_CLR: return "R5";
            C_RL, C_RR, C_RLC, C_RRC: return "R6";
            C_SWAP: return "R7";
            C_XCHD: return "R8";
            C_SETC, C_CLRC: return "R9";
            C_LDA, C_WRPSW: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Drive one command at the falling edge, check one time unit after the rising edge.
    task automatic apply(input int o, input logic [7:0] b);
        @(negedge clk);
        op_code = 5'(o);
        operand = b;
        model_step(o, b);
        @(posedge clk);
        #1;
        check(tag_of(o));
    endtask

    task automatic arith_case(input logic [7:0] a, input logic [7:0] b, input int c);
        apply(C_LDA, a);
        apply(c != 0 ? C_SETC : C_CLRC, 8'h00);
        apply(C_ADDC, b);
        apply(C_LDA, a);
        apply(c != 0 ? C_SETC : C_CLRC, 8'h00);
        apply(C_SUBB, b);
        if (c == 0) begin
            apply(C_LDA, a);
            apply(C_ADD, b);
        end
    endtask

    task automatic reset_check();
        @(negedge clk);
        rst_n = 1'b0;
        op_code = 5'(C_NOP);
        @(posedge clk);
        @(negedge clk);
        m_acc = '0; m_psw = '0; m_wbe = 1'b0; m_wbd = '0;
        n_chk++;
        if (acc_q !== 8'h00 || psw_q !== 8'h00 || wb_en !== 1'b0 || wb_data !== 8'h00) begin
            n_err++;
            $display("FAIL R1 acc=%h psw=%h wbe=%b wbd=%h expected all zero",
                     acc_q, psw_q, wb_en, wb_data);
        end
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #800000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        logic [7:0] corners [8];
        int lops [11];
        corners = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'h81, 8'hFF};
        lops = '{C_AND, C_OR, C_XOR, C_CPL, C_CLR, C_RL, C_RR, C_RLC, C_RRC, C_SWAP, C_XCHD};
        repeat (3) @(posedge clk);
        reset_check();

        // Arithmetic grid with both carry-in values.
        for (int a = 0; a < 256; a += 5)
            for (int b = 0; b < 256; b += 3)
                for (int c = 0; c < 2; c++)
                    arith_case(8'(a), 8'(b), c);
        // Sign and nibble boundaries.
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                for (int c = 0; c < 2; c++)
                    arith_case(corners[i], corners[j], c);

        // Logic, rotate, swap and exchange with a varied flag byte loaded first.
        for (int a = 0; a < 256; a++)
            for (int k = 0; k < 11; k++) begin
                apply(C_WRPSW, 8'((a * 37 + k * 91) % 256));
                apply(C_LDA, 8'(a));
                apply(lops[k], 8'((a * 7 + k * 29 + 3) % 256));
            end

        // Flag-byte writes that try to set parity the wrong way, carry commands.
        for (int v = 0; v < 256; v++) begin
            apply(C_LDA, 8'(v * 3));
            apply(C_WRPSW, 8'(v));
            apply(C_SETC, 8'hFF);
            apply(C_CLRC, 8'hFF);
        end

        // No-op and unassigned codes leave everything unchanged.
        apply(C_LDA, 8'hA7);
        apply(C_WRPSW, 8'h7A);
        for (int o = 19; o < 32; o++) apply(o, 8'h5C);
        apply(C_NOP, 8'hFF);

        // Reset in the middle of activity, including a pending write-back.
        apply(C_XCHD, 8'h3E);
        reset_check();
        apply(C_NOP, 8'h00);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule